// File: doc/BRIEF.md
# Core Migration Power Sequencer

This controller moves one running thread between cores on a die where only one core runs at a time and each core type exists once. A switch request names a target core. The sequencer works through a fixed order. It first drains the running core's pipeline, then has the dirty L1 data lines written back to the shared L2. Next it brings up the target core's supply in stages and releases the target to fetch from a fixed entry address. Last, once the new core asks for it, the old core is shut off completely.

The clock generator that feeds all cores is shared and never stopped, so bring-up time is only the supply settling time. That time is split into `NUM_STAGES` equal steps of `STAGE_CYCLES` clocks each. With the defaults of 4 × 250 this comes to 1000 cycles. Cores that are not in use keep every supply enable low and stay held in reset. The pipeline, cache, power switches and cores are outside the block and talk to it through simple handshakes.

Top module: `mig_sequencer`

## Requirements
- R1: After reset, core `RESET_CORE` (default 0) has all of its supply enables high and `core_rst_n` high, every other core has all enables low and `core_rst_n` low, `active_core` equals `RESET_CORE`, and `sw_busy`, `sw_ack`, `sw_done` and `core_start` are low.
- R2: A request (`sw_req` high at a clock edge while idle) naming a valid core other than `active_core` raises `sw_ack` for exactly one cycle after that edge. `sw_busy` and `drain_req` then stay high until `drain_done` is sampled high.
- R3: `wb_req` rises only on the edge that samples `drain_done`, and it stays high until `wb_done` is sampled. No supply enable changes while `drain_req` is high.
- R4: Supply enables are laid out as `dom_en[core*NUM_STAGES + stage]`. Stage bit 0 of the target rises on the edge that samples `wb_done`. Stage bit k rises k×`STAGE_CYCLES` cycles later, lowest bit first, with exactly one new bit per step.
- R5: `NUM_STAGES`×`STAGE_CYCLES` cycles after stage bit 0 rose, with every stage bit of the target high, the target's `core_rst_n` goes high and its `core_start` bit pulses for one cycle. `start_vec` always equals `ENTRY_VEC`.
- R6: While waiting for the hand-off, a sampled `old_off_req` clears all of the old core's enables and drives its `core_rst_n` low on the same edge. On that edge `active_core` takes the target's number, `sw_done` pulses for one cycle and `sw_busy` falls.
- R7: An idle request whose target equals `active_core`, or is not below `NUM_CORES`, raises `sw_ack` for one cycle and changes nothing else.
- R8: `sw_req` while `sw_busy` is high gets no `sw_ack` and does not change the target of the switch in progress.
- R9: `old_off_req` is ignored outside the hand-off wait. The old core keeps its enables and stays out of reset.
- R10: While idle exactly one core has `core_rst_n` high. At most two have it high at any time, and two only between the target's start and the old core's shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, never gated |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req | input | 1 | Switch request |
| sw_target | input | IDX_W | Requested core number |
| sw_ack | output | 1 | One-cycle acknowledge of an accepted request |
| sw_busy | output | 1 | A switch is in progress |
| drain_req | output | 1 | Ask the running core to flush its pipeline |
| drain_done | input | 1 | Pipeline flush finished |
| wb_req | output | 1 | Ask for dirty L1 data lines to be written to L2 |
| wb_done | input | 1 | Write-back finished |
| dom_en | output | NUM_CORES*NUM_STAGES | Per-core staged supply enables |
| core_rst_n | output | NUM_CORES | Per-core reset, low holds the core |
| core_start | output | NUM_CORES | One-cycle start pulse per core |
| start_vec | output | ADDR_W | Entry address for a started core |
| old_off_req | input | 1 | New core asks for the old core to be shut down |
| sw_done | output | 1 | One-cycle pulse once the old core is off |
| active_core | output | IDX_W | Number of the running core |

## Verification
The assertions check the ordering rules on every cycle. They confirm that no supply changes during the drain, that write-back follows the drain, that each power step adds exactly one bit and that a start pulse only reaches a fully powered core. They also check that no busy request is acknowledged and that at most one core runs when idle. The exact cycle on which each stage bit rises, the 1000-cycle start delay and the handling of same-core and out-of-range targets need the bench. So does the fact that a stray `old_off_req` or request during bring-up leaves the state untouched. The bench shows these by comparing every output against its timed reference model.

// File: rtl/mig_pkg.sv
package mig_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_DRAIN   = 3'd1,
    PH_WB      = 3'd2,
    PH_PWR     = 3'd3,
    PH_HANDOFF = 3'd4
  } mig_phase_e;

  // total bring-up time in cycles
  function automatic int unsigned bringup_cycles(int unsigned stages, int unsigned per_stage);
    return stages * per_stage;
  endfunction

  // flat position of one supply stage bit
  function automatic int unsigned dom_bit(int unsigned core, int unsigned stage, int unsigned stages);
    return core * stages + stage;
  endfunction

endpackage

// File: rtl/mig_stage_timer.sv
module mig_stage_timer #(
  parameter int NUM_STAGES   = 4,
  parameter int STAGE_CYCLES = 250,
  localparam int STG_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
  localparam int CNT_W = (STAGE_CYCLES > 1) ? $clog2(STAGE_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  output logic [STG_W-1:0] stage_idx,
  output logic             stage_tick,
  output logic             final_tick
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STAGE_CYCLES - 1);
  localparam logic [STG_W-1:0] STG_LAST = STG_W'(NUM_STAGES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [STG_W-1:0] stg_q;
  logic             boundary;

  assign boundary   = run && (cnt_q == CNT_LAST);
  assign stage_tick = boundary && (stg_q != STG_LAST);
  assign final_tick = boundary && (stg_q == STG_LAST);
  assign stage_idx  = stg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stg_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
      stg_q <= '0;
    end else if (run) begin
      if (boundary) begin
        cnt_q <= '0;
        if (stg_q != STG_LAST) stg_q <= stg_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mig_domain_bank.sv
module mig_domain_bank #(
  parameter int NUM_CORES  = 5,
  parameter int NUM_STAGES = 4,
  parameter int RESET_CORE = 0,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int STG_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            up_en,
  input  logic [IDX_W-1:0]                up_core,
  input  logic [STG_W-1:0]                up_stage,
  input  logic                            rel_en,
  input  logic [IDX_W-1:0]                rel_core,
  input  logic                            off_en,
  input  logic [IDX_W-1:0]                off_core,
  output logic [NUM_CORES*NUM_STAGES-1:0] dom_en,
  output logic [NUM_CORES-1:0]            core_rst_n,
  output logic [NUM_CORES-1:0]            core_start
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    localparam bit IS_BOOT = (c == RESET_CORE);
    logic [NUM_STAGES-1:0] dom_q;
    logic                  rel_q;
    logic                  start_q;
    logic                  hit_up, hit_rel, hit_off;

    assign hit_up  = up_en  && (up_core  == IDX_W'(c));
    assign hit_rel = rel_en && (rel_core == IDX_W'(c));
    assign hit_off = off_en && (off_core == IDX_W'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dom_q   <= IS_BOOT ? {NUM_STAGES{1'b1}} : '0;
        rel_q   <= IS_BOOT;
        start_q <= 1'b0;
      end else begin
        start_q <= hit_rel;
        if (hit_off) begin
          dom_q <= '0;
          rel_q <= 1'b0;
        end else begin
          if (hit_up)  dom_q[up_stage] <= 1'b1;
          if (hit_rel) rel_q <= 1'b1;
        end
      end
    end

    assign dom_en[c*NUM_STAGES +: NUM_STAGES] = dom_q;
    assign core_rst_n[c] = rel_q;
    assign core_start[c] = start_q;
  end
endmodule

// File: rtl/mig_sequencer.sv
module mig_sequencer
  import mig_pkg::*;
#(
  parameter int NUM_CORES    = 5,
  parameter int NUM_STAGES   = 4,
  parameter int STAGE_CYCLES = 250,
  parameter int RESET_CORE   = 0,
  parameter int ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] ENTRY_VEC = 32'h0000_1000,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int STG_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
  localparam int DOM_W = NUM_CORES * NUM_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_req,
  input  logic [IDX_W-1:0]  sw_target,
  output logic              sw_ack,
  output logic              sw_busy,
  output logic              drain_req,
  input  logic              drain_done,
  output logic              wb_req,
  input  logic              wb_done,
  output logic [DOM_W-1:0]  dom_en,
  output logic [NUM_CORES-1:0] core_rst_n,
  output logic [NUM_CORES-1:0] core_start,
  output logic [ADDR_W-1:0] start_vec,
  input  logic              old_off_req,
  output logic              sw_done,
  output logic [IDX_W-1:0]  active_core
);
  mig_phase_e       phase_q;
  logic [IDX_W-1:0] tgt_q;
  logic [IDX_W-1:0] act_q;
  logic             ack_q, done_q;

  // named internal events
  logic             evt_accept;   // request taken, switch begins
  logic             evt_trivial;  // request taken, nothing to do
  logic             evt_stage_up; // one supply stage bit raised
  logic             evt_release;  // target leaves reset
  logic             evt_retire;   // old core shut off

  logic [STG_W-1:0] stage_idx;
  logic             stage_tick, final_tick;
  logic [STG_W-1:0] up_stage;
  logic             target_ok;

  assign target_ok   = (int'(sw_target) < NUM_CORES) && (sw_target != act_q);
  assign evt_accept  = (phase_q == PH_IDLE) && sw_req && target_ok;
  assign evt_trivial = (phase_q == PH_IDLE) && sw_req && !target_ok;
  assign evt_stage_up = ((phase_q == PH_WB) && wb_done) || stage_tick;
  assign up_stage    = (phase_q == PH_WB) ? '0 : STG_W'(stage_idx + 1'b1);
  assign evt_release = final_tick;
  assign evt_retire  = (phase_q == PH_HANDOFF) && old_off_req;

  mig_stage_timer #(
    .NUM_STAGES  (NUM_STAGES),
    .STAGE_CYCLES(STAGE_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      ((phase_q == PH_WB) && wb_done),
    .run       (phase_q == PH_PWR),
    .stage_idx (stage_idx),
    .stage_tick(stage_tick),
    .final_tick(final_tick)
  );

  mig_domain_bank #(
    .NUM_CORES (NUM_CORES),
    .NUM_STAGES(NUM_STAGES),
    .RESET_CORE(RESET_CORE)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_en     (evt_stage_up),
    .up_core   (tgt_q),
    .up_stage  (up_stage),
    .rel_en    (evt_release),
    .rel_core  (tgt_q),
    .off_en    (evt_retire),
    .off_core  (act_q),
    .dom_en    (dom_en),
    .core_rst_n(core_rst_n),
    .core_start(core_start)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      tgt_q   <= IDX_W'(RESET_CORE);
      act_q   <= IDX_W'(RESET_CORE);
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ack_q  <= evt_accept || evt_trivial;
      done_q <= evt_retire;
      unique case (phase_q)
        PH_IDLE: if (evt_accept) begin
          tgt_q   <= sw_target;
          phase_q <= PH_DRAIN;
        end
        PH_DRAIN:   if (drain_done) phase_q <= PH_WB;
        PH_WB:      if (wb_done) phase_q <= PH_PWR;
        PH_PWR:     if (evt_release) phase_q <= PH_HANDOFF;
        PH_HANDOFF: if (evt_retire) begin
          act_q   <= tgt_q;
          phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign sw_ack      = ack_q;
  assign sw_done     = done_q;
  assign sw_busy     = (phase_q != PH_IDLE);
  assign drain_req   = (phase_q == PH_DRAIN);
  assign wb_req      = (phase_q == PH_WB);
  assign active_core = act_q;
  assign start_vec   = ENTRY_VEC;
endmodule

// File: rtl/mig_sequencer_chk.sv
module mig_sequencer_chk #(
  parameter int NUM_CORES  = 5,
  parameter int NUM_STAGES = 4,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int DOM_W = NUM_CORES * NUM_STAGES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_req,
  input logic             sw_ack,
  input logic             sw_busy,
  input logic             drain_req,
  input logic             drain_done,
  input logic             wb_req,
  input logic [DOM_W-1:0] dom_en,
  input logic [NUM_CORES-1:0] core_rst_n,
  input logic [NUM_CORES-1:0] core_start,
  input logic             sw_done,
  input logic [IDX_W-1:0] active_core,
  input logic             evt_stage_up
);
  logic [NUM_CORES-1:0] core_full;
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_full
    assign core_full[c] = &dom_en[c*NUM_STAGES +: NUM_STAGES];
  end

  AST_IDLE_ONE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_busy |-> $countones(core_rst_n) == 1); // R10
  AST_AT_MOST_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(core_rst_n) <= 2); // R10
  AST_WB_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_req) |-> $past(drain_req) && $past(drain_done)); // R3
  AST_NO_POWER_DURING_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req |=> $stable(dom_en)); // R3
  AST_ONE_BIT_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stage_up |=> $countones(dom_en) == $past($countones(dom_en)) + 1); // R4
  AST_START_FULL_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    (core_start & ~core_full) == '0); // R5
  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_start)); // R5
  AST_DONE_SINGLE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_done |-> ($countones(core_rst_n) == 1) && core_rst_n[active_core] && core_full[active_core]); // R6
  AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_busy && sw_req) |=> !sw_ack); // R8
endmodule

bind mig_sequencer mig_sequencer_chk #(
  .NUM_CORES (NUM_CORES),
  .NUM_STAGES(NUM_STAGES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sw_req      (sw_req),
  .sw_ack      (sw_ack),
  .sw_busy     (sw_busy),
  .drain_req   (drain_req),
  .drain_done  (drain_done),
  .wb_req      (wb_req),
  .dom_en      (dom_en),
  .core_rst_n  (core_rst_n),
  .core_start  (core_start),
  .sw_done     (sw_done),
  .active_core (active_core),
  .evt_stage_up(evt_stage_up)
);

// File: tb/tb_mig_sequencer.sv
module tb_mig_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 5;
  localparam int NS = 4;
  localparam int SC = 250;
  localparam int IW = 3;
  localparam int DW = NC * NS;
  localparam logic [31:0] ENTRY = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_req = 1'b0;
  logic [IW-1:0] sw_target = '0;
  logic sw_ack, sw_busy, drain_req, wb_req, sw_done;
  logic drain_done = 1'b0, wb_done = 1'b0, old_off_req = 1'b0;
  logic [DW-1:0] dom_en;
  logic [NC-1:0] core_rst_n, core_start;
  logic [31:0] start_vec;
  logic [IW-1:0] active_core;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit cmp_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mig_sequencer dut (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_target(sw_target),
    .sw_ack(sw_ack), .sw_busy(sw_busy), .drain_req(drain_req),
    .drain_done(drain_done), .wb_req(wb_req), .wb_done(wb_done),
    .dom_en(dom_en), .core_rst_n(core_rst_n), .core_start(core_start),
    .start_vec(start_vec), .old_off_req(old_off_req), .sw_done(sw_done),
    .active_core(active_core)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_ph, m_act, m_tgt, m_t;
  logic [NC-1:0] m_on, m_rst, m_start;
  bit m_ack, m_done;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_act = 0; m_tgt = 0; m_t = 0;
      m_on = 5'b00001; m_rst = 5'b00001; m_start = '0;
      m_ack = 0; m_done = 0;
    end else begin
      m_ack = 0; m_done = 0; m_start = '0;
      case (m_ph)
        0: if (sw_req) begin
             m_ack = 1;
             if (int'(sw_target) < NC && int'(sw_target) != m_act) begin
               m_tgt = int'(sw_target); m_ph = 1;
             end
           end
        1: if (drain_done) m_ph = 2;
        2: if (wb_done) begin m_ph = 3; m_t = 0; end
        3: begin
             if (m_t + 1 == NS * SC) begin
               m_on[m_tgt] = 1; m_rst[m_tgt] = 1; m_start[m_tgt] = 1; m_ph = 4;
             end
             m_t = m_t + 1;
           end
        4: if (old_off_req) begin
             m_on[m_act] = 0; m_rst[m_act] = 0; m_act = m_tgt; m_done = 1; m_ph = 0;
           end
        default: m_ph = 0;
      endcase
    end
  end

  function automatic logic [DW-1:0] exp_dom();
    logic [DW-1:0] v = '0;
    for (int c = 0; c < NC; c++) begin
      for (int s = 0; s < NS; s++) begin
        if (m_on[c]) v[c*NS+s] = 1'b1;
        else if (m_ph == 3 && c == m_tgt) v[c*NS+s] = (s <= m_t / SC);
      end
    end
    return v;
  endfunction

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk(dom_en == exp_dom(), "R4 supply enables", dom_en, exp_dom());
      chk(core_rst_n == m_rst, "R10 core resets", core_rst_n, m_rst);
      chk(core_start == m_start, "R5 start pulse", core_start, m_start);
      chk(int'(active_core) == m_act, "R6 active core", active_core, m_act);
      chk(sw_ack == m_ack, "R7 ack", sw_ack, m_ack);
      chk(sw_busy == (m_ph != 0), "R8 busy", sw_busy, m_ph != 0);
      chk(sw_done == m_done, "R6 done", sw_done, m_done);
      chk(drain_req == (m_ph == 1), "R2 drain req", drain_req, m_ph == 1);
      chk(wb_req == (m_ph == 2), "R3 writeback req", wb_req, m_ph == 2);
      chk(start_vec == ENTRY, "R5 entry vector", start_vec, ENTRY);
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic int slice_ones(int core);
    int n = 0;
    for (int s = 0; s < NS; s++) n += dom_en[core*NS+s];
    return n;
  endfunction

  task automatic request(input int tgt);
    sw_req = 1'b1; sw_target = IW'(tgt);
    @(negedge clk);
    sw_req = 1'b0;
  endtask

  task automatic do_switch(input int tgt, input int dd, input int wd, input int od, input bit intrude);
    int old = int'(active_core);
    int k;
    request(tgt);
    chk(sw_ack == 1'b1, "R2 ack after request", sw_ack, 1);
    chk(drain_req == 1'b1, "R2 drain requested", drain_req, 1);
    repeat (dd) @(negedge clk);
    chk(wb_req == 1'b0, "R3 no writeback before drain done", wb_req, 0);
    drain_done = 1'b1; @(negedge clk); drain_done = 1'b0;
    chk(wb_req == 1'b1, "R3 writeback after drain", wb_req, 1);
    repeat (wd) @(negedge clk);
    wb_done = 1'b1; @(negedge clk); wb_done = 1'b0;
    chk(slice_ones(tgt) == 1, "R4 first stage bit", slice_ones(tgt), 1);
    k = 0;
    while (core_start == '0 && k < 5000) begin
      if (intrude && k == 100) begin
        sw_req = 1'b1; sw_target = IW'((tgt + 1) % NC); old_off_req = 1'b1;
        @(negedge clk); k++;
        sw_req = 1'b0; old_off_req = 1'b0;
        chk(sw_ack == 1'b0, "R8 busy request not acked", sw_ack, 0);
        chk(core_rst_n[old] == 1'b1, "R9 early off ignored", core_rst_n[old], 1);
        chk(slice_ones(old) == NS, "R9 old supply kept", slice_ones(old), NS);
      end else begin
        @(negedge clk); k++;
      end
      if (k == SC + 1) chk(slice_ones(tgt) == 2, "R4 second stage bit", slice_ones(tgt), 2);
    end
    chk(k == NS * SC, "R5 start delay", k, NS * SC);
    chk(core_start == NC'(1 << tgt), "R5 start on target", core_start, 1 << tgt);
    repeat (od) @(negedge clk);
    chk(core_rst_n[old] == 1'b1, "R9 old running until request", core_rst_n[old], 1);
    old_off_req = 1'b1; @(negedge clk); old_off_req = 1'b0;
    chk(sw_done == 1'b1, "R6 done pulse", sw_done, 1);
    chk(int'(active_core) == tgt, "R6 active updated", active_core, tgt);
    chk(slice_ones(old) == 0 && core_rst_n[old] == 1'b0, "R6 old core off", slice_ones(old), 0);
    chk(sw_busy == 1'b0, "R6 busy cleared", sw_busy, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1;
    chk(dom_en == DW'(4'hF), "R1 reset supply", dom_en, 4'hF);
    chk(core_rst_n == 5'b00001, "R1 reset release", core_rst_n, 1);
    chk(active_core == '0 && !sw_busy, "R1 idle on boot core", active_core, 0);

    request(0);
    chk(sw_ack && !sw_busy, "R7 same core acked only", sw_ack, 1);
    @(negedge clk);
    chk(dom_en == DW'(4'hF) && !drain_req, "R7 same core no change", dom_en, 4'hF);

    request(7);
    chk(sw_ack && !sw_busy, "R7 out of range acked only", sw_ack, 1);
    @(negedge clk);
    chk(active_core == '0, "R7 out of range no change", active_core, 0);

    do_switch(3, 3, 5, 4, 1'b1);
    do_switch(1, 0, 0, 0, 1'b0);
    do_switch(0, 2, 1, 7, 1'b0);

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule